// File: doc/BRIEF.md
# Crystal Reference Divider with Band-Dependent Channel Step

This block turns a crystal clock into the two timing references a tuning synthesizer needs. A first counter divides the crystal by 1, 80, 160 or 205, picked by a 2-bit prescale code. The ratio is matched to the fitted crystal (4, 8 or 10.25 MHz), so each setting yields a 50 kHz internal tick. The divide-by-1 setting is kept for test. The 50 kHz tick also serves as the time base for other timers, such as the frequency-counter gate.

A second counter counts those ticks down to the channel-step comparison rate for the phase detector. A band bit selects the ratio table, and a 2-bit step code picks an entry from it. In the FM band the comparison rate is 12.5, 25 or 50 kHz. In the AM band it is 1, 5 or 10 kHz. Both outputs are enable pulses one crystal cycle wide, not derived clocks.

When a code changes, the counter it controls picks up the new ratio only at its next terminal count. The period in progress therefore always finishes cleanly.

Top module: `refdiv_top`

## Requirements
- R1: The prescale code selects the tick period in crystal cycles: `pre_sel`=00 gives 1, 01 gives 80, 10 gives 160, 11 gives 205. `tick_ref` is high for one cycle at the end of each period.
- R2: With `band_am`=0 (FM band), `step_sel`=01, 10 and 11 divide the tick by 4, 2 and 1. `cmp_pulse` is high on the last tick of each group.
- R3: With `band_am`=1 (AM band), `step_sel`=01, 10 and 11 divide the tick by 50, 10 and 5.
- R4: `step_sel`=00 is reserved and keeps `cmp_pulse` low. When the code leaves 00, the new ratio is taken at the next tick, and counting starts from the tick after that.
- R5: `cmp_pulse` is only ever high in a cycle where `tick_ref` is also high.
- R6: A new prescale code takes effect only after the next `tick_ref`. The period in progress completes with the old ratio.
- R7: A new band or step code takes effect only after the next `cmp_pulse`. The comparison period in progress completes with the old ratio.
- R8: `rst` is synchronous and active high. Both outputs stay low while it is asserted. Count cycles from 0 at the first cycle after release. The first tick then comes in cycle N-1, and the first comparison pulse in cycle N*M-1, where N is the prescale ratio and M is the step ratio.
- R9: Each counter stays below its loaded ratio and advances by exactly one on every enabled cycle that is not a reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous reset, active high |
| pre_sel | input | 2 | Prescale ratio code |
| band_am | input | 1 | Band select: 1 = AM, 0 = FM |
| step_sel | input | 2 | Channel-step code, 00 reserved |
| tick_ref | output | 1 | 50 kHz tick, one crystal cycle wide |
| cmp_pulse | output | 1 | Comparison-rate pulse for the phase detector |

## Verification
The counter assertions assume that the code inputs change only between clock edges. They also assume that a ratio of zero can reach only the second stage, because the prescale table has no zero entry. The bench changes codes half a cycle away from the active edge, and only after it has sampled that cycle. It sweeps all 32 combinations of prescale, band and step code. For each one it compares every cycle of two full comparison periods against periods computed in the bench. Separate runs change the prescale code in the middle of a tick period, change the step code in the middle of a comparison period, and move the step code out of the reserved value. Each of these runs checks the exact cycle of the following pulses.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  typedef enum logic {
    BAND_FM = 1'b0,
    BAND_AM = 1'b1
  } band_e;

  // Map a 2-bit code onto one of four ratios.
  function automatic int unsigned pick_ratio(
    input logic [1:0]  code,
    input int unsigned r0,
    input int unsigned r1,
    input int unsigned r2,
    input int unsigned r3
  );
    case (code)
      2'b00:   return r0;
      2'b01:   return r1;
      2'b10:   return r2;
      default: return r3;
    endcase
  endfunction

  function automatic int unsigned max4(
    input int unsigned a,
    input int unsigned b,
    input int unsigned c,
    input int unsigned d
  );
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/refdiv_cnt.sv
// Modulo counter with reload at terminal count; a zero ratio is silent.
module refdiv_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] ratio_in,
  output logic         pulse,
  output logic         reload_ev
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_q;
  logic         lim_zero;
  logic         at_end;

  assign lim_zero  = (lim_q == '0);
  assign at_end    = !lim_zero && (cnt_q == lim_q - W'(1));
  assign reload_ev = adv && (at_end || lim_zero);
  assign pulse     = adv && at_end && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= ratio_in;
    end else if (adv) begin
      if (at_end || lim_zero) begin
        cnt_q <= '0;
        lim_q <= ratio_in;
      end else begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

  // R9: count stays below the loaded ratio
  p_cnt_in_range_r9: assert property (@(posedge clk) disable iff (rst)
    !lim_zero |-> (cnt_q < lim_q));

  // R9: one step per enabled cycle that is not a reload
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (rst)
    (adv && !reload_ev) |=> (cnt_q == $past(cnt_q) + W'(1)));

  // R6 / R7: ratio is only taken at a reload event
  p_lim_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !reload_ev |=> $stable(lim_q));

  // R4: a zero ratio never produces a pulse
  p_zero_silent_r4: assert property (@(posedge clk) disable iff (rst)
    lim_zero |-> !pulse);

endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
  parameter int unsigned PRE_D0 = 1,
  parameter int unsigned PRE_D1 = 80,
  parameter int unsigned PRE_D2 = 160,
  parameter int unsigned PRE_D3 = 205,
  parameter int unsigned FM_D1  = 4,
  parameter int unsigned FM_D2  = 2,
  parameter int unsigned FM_D3  = 1,
  parameter int unsigned AM_D1  = 50,
  parameter int unsigned AM_D2  = 10,
  parameter int unsigned AM_D3  = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pre_sel,
  input  logic       band_am,
  input  logic [1:0] step_sel,
  output logic       tick_ref,
  output logic       cmp_pulse
);
  import refdiv_pkg::*;

  localparam int unsigned PRE_MAX  = max4(PRE_D0, PRE_D1, PRE_D2, PRE_D3);
  localparam int unsigned STEP_MAX = max4(max4(FM_D1, FM_D2, FM_D3, 1),
                                          AM_D1, AM_D2, AM_D3);
  localparam int PW = $clog2(PRE_MAX + 1);
  localparam int SW = $clog2(STEP_MAX + 1);

  band_e        band;
  logic [PW-1:0] pre_ratio;
  logic [SW-1:0] step_ratio;
  logic          pre_reload;
  logic          step_reload;

  assign band      = band_e'(band_am);
  assign pre_ratio = PW'(pick_ratio(pre_sel, PRE_D0, PRE_D1, PRE_D2, PRE_D3));

  always_comb begin
    if (band == BAND_AM)
      step_ratio = SW'(pick_ratio(step_sel, 0, AM_D1, AM_D2, AM_D3));
    else
      step_ratio = SW'(pick_ratio(step_sel, 0, FM_D1, FM_D2, FM_D3));
  end

  refdiv_cnt #(.W(PW)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .adv       (1'b1),
    .ratio_in  (pre_ratio),
    .pulse     (tick_ref),
    .reload_ev (pre_reload)
  );

  refdiv_cnt #(.W(SW)) u_step (
    .clk       (clk),
    .rst       (rst),
    .adv       (tick_ref),
    .ratio_in  (step_ratio),
    .pulse     (cmp_pulse),
    .reload_ev (step_reload)
  );

  // R5: comparison pulse lands on a tick
  p_cmp_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
    cmp_pulse |-> tick_ref);

  // R7: the second stage reloads only on a tick
  p_step_reload_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    step_reload |-> tick_ref);

  // R6: the prescaler reloads exactly when it ticks
  p_pre_reload_is_tick_r6: assert property (@(posedge clk) disable iff (rst)
    pre_reload == tick_ref);

endmodule

// File: tb/refdiv_top_test.sv
module refdiv_top_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] pre_sel = 2'b01;
  logic       band_am = 1'b0;
  logic [1:0] step_sel = 2'b11;
  logic       tick_ref;
  logic       cmp_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  refdiv_top uut (
    .clk(clk), .rst(rst), .pre_sel(pre_sel), .band_am(band_am),
    .step_sel(step_sel), .tick_ref(tick_ref), .cmp_pulse(cmp_pulse)
  );

  function automatic int exp_pre(input logic [1:0] c);
    case (c)
      2'b00: return 1;
      2'b01: return 80;
      2'b10: return 160;
      default: return 205;
    endcase
  endfunction

  function automatic int exp_step(input logic am, input logic [1:0] c);
    if (c == 2'b00) return 0;
    if (am) return (c == 2'b01) ? 50 : (c == 2'b10) ? 10 : 5;
    return (c == 2'b01) ? 4 : (c == 2'b10) ? 2 : 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
    #1;
  endtask

  // Reset with given codes; outputs must stay low (R8). Returns at cycle 0.
  task automatic do_reset(input logic [1:0] p, input logic a, input logic [1:0] s);
    @(negedge clk);
    rst = 1'b1; pre_sel = p; band_am = a; step_sel = s;
    for (int i = 0; i < 3; i++) begin
      next_cycle();
      chk(!tick_ref && !cmp_pulse, "R8 outputs low in reset",
          int'({tick_ref, cmp_pulse}), 0);
    end
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  // Collect pulse positions of one output over a window
  task automatic collect(input int len, input bit use_cmp, output int pos[8], output int n);
    n = 0;
    for (int c = 0; c < len; c++) begin
      if (c > 0) next_cycle();
      if ((use_cmp ? cmp_pulse : tick_ref) && n < 8) begin
        pos[n] = c;
        n++;
      end
    end
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8, R1 with divide-by-1 held in reset, and the full sweep R1 R2 R3 R4 R5 R8
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 2; a++) begin
        for (int s = 0; s < 4; s++) begin
          int n, m, len, bad_t, bad_c, first_t, first_c, cmp_no_tick;
          n = exp_pre(2'(p));
          m = exp_step(a[0], 2'(s));
          len = (m == 0) ? 6 * n : 2 * n * m;
          bad_t = 0; bad_c = 0; first_t = -1; first_c = -1; cmp_no_tick = 0;
          do_reset(2'(p), a[0], 2'(s));
          for (int c = 0; c < len; c++) begin
            bit et, ec;
            if (c > 0) next_cycle();
            et = ((c + 1) % n) == 0;
            ec = (m != 0) && (((c + 1) % (n * m)) == 0);
            if (tick_ref !== et) begin bad_t++; if (first_t < 0) first_t = c; end
            if (cmp_pulse !== ec) begin bad_c++; if (first_c < 0) first_c = c; end
            if (cmp_pulse && !tick_ref) cmp_no_tick++;
          end
          // R1 / R8: tick period and first tick after release
          chk(bad_t == 0, "R1 R8 tick pattern", first_t, -1);
          // R2 (FM) / R3 (AM) / R4 (reserved): comparison pattern
          if (m == 0)
            chk(bad_c == 0, "R4 reserved step keeps cmp low", first_c, -1);
          else if (a == 1)
            chk(bad_c == 0, "R3 AM cmp pattern", first_c, -1);
          else
            chk(bad_c == 0, "R2 FM cmp pattern", first_c, -1);
          chk(cmp_no_tick == 0, "R5 cmp only with tick", cmp_no_tick, 0);
        end
      end
    end

    // R6: prescale change mid-period, old period completes
    begin
      int pos[8]; int n1, n2;
      do_reset(2'b01, 1'b0, 2'b11);
      collect(41, 1'b0, pos, n1);
      pre_sel = 2'b11;
      collect(460, 1'b0, pos, n2);
      // cycles counted from 40 in second window: ticks at 79, 284, 489
      chk(n2 == 3, "R6 tick count after prescale change", n2, 3);
      chk(pos[0] == 39, "R6 old period completes", pos[0] + 40, 79);
      chk(pos[1] == 244, "R6 new period 205", pos[1] + 40, 284);
      chk(pos[2] == 449, "R6 steady new period", pos[2] + 40, 489);
    end

    // R7: step change mid comparison period, AM band
    begin
      int pos[8]; int n1, n2;
      do_reset(2'b01, 1'b1, 2'b11);
      collect(501, 1'b1, pos, n1);
      chk(n1 == 2 && pos[0] == 399 && pos[1] == 799 || n1 == 1 && pos[0] == 399,
          "R7 cmp before change", pos[0], 399);
      step_sel = 2'b01;
      collect(4400, 1'b1, pos, n2);
      chk(n2 == 2, "R7 cmp count after step change", n2, 2);
      chk(pos[0] == 299, "R7 old comparison period completes", pos[0] + 500, 799);
      chk(pos[1] == 4299, "R7 new ratio 50 ticks", pos[1] + 500, 4799);
    end

    // R4: leaving the reserved code
    begin
      int pos[8]; int n1, n2;
      do_reset(2'b01, 1'b0, 2'b00);
      collect(201, 1'b1, pos, n1);
      chk(n1 == 0, "R4 no cmp while reserved", n1, 0);
      step_sel = 2'b11;
      collect(221, 1'b1, pos, n2);
      chk(n2 == 2, "R4 cmp count after leaving reserved", n2, 2);
      chk(pos[0] == 119, "R4 first cmp on second tick", pos[0] + 200, 319);
      chk(pos[1] == 199, "R4 following cmp", pos[1] + 200, 399);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule